// File: doc/BRIEF.md
# Page Protection Check and Fault Recorder

This block sits behind a page-table walker in a reference-style memory management unit. For each request it takes the leaf page entry's 3-bit access code and modified bit, together with the request's kind (load, store, fetch) and privilege. In the same cycle it decides whether the request raises a protection fault, and which read, write and execute rights may be placed in the translation cache. It also picks the trap class for a raised fault.

When a walker fault or a protection fault occurs, the block records a status word and the faulting virtual address. Software reads both through a small register read port. Reading the status word clears it. A status word that is overwritten before anyone reads it is marked as overflowed. A no-fault control input lets user-mode protection faults pass silently.

Top module: `mmu_prot_check`

## Requirements
- R1: The request index is {store, fetch, supervisor} (store at bit 2, supervisor = not user). A recorded fault writes this index into status bits 7:5.
- R2: The fault type comes from the index and the access code. A user request on access code 6 or 7 yields 3 (privilege). Otherwise a request lacking the right it needs yields 2 (protection): a store needs write, a fetch needs execute, a store-fetch needs both, and any other request needs read. No fault yields 0. A non-zero type raises `fault_o` and is recorded at status bits 4:2.
- R3: When `nofault_en` is high and the request is from user mode, a protection fault is neither raised nor recorded. The rights of R4 are still granted.
- R4: Rights {r,w,x} per access code 0..7. User mode: r, rw, rx, rwx, x, r, none, none. Supervisor mode: the same, except codes 5, 6 and 7 give rw, rx and rwx. Rights are granted only for a valid request that raises no fault and has no walker error.
- R5: Write rights are withheld whenever `pte_mod` is 0.
- R6: A recorded fault sets status bit 1. If the status word was non-zero and was not read in that cycle, the new value is first seeded with 1 (overflow bit 0).
- R7: A recorded fault copies `req_va` into the address register.
- R8: A raised fault drives `trap_sel` to 2'b01 for a fetch and to 2'b10 otherwise. With no fault it is 2'b00.
- R9: A walker error is always recorded, with `walk_code` ORed into the status word. It raises `fault_o` only when `nofault_en` is 0. It grants no rights.
- R10: A read with `rd_sel`=0 returns the status word and with `rd_sel`=1 the address register. The data appears on `rd_data` with `rd_valid` one cycle after `rd_en`.
- R11: Reading the status word clears it at that clock edge. A fault recorded in the same cycle replaces it with fresh bits and no overflow.
- R12: After reset the status word, the address register, `rd_valid` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | VA_W | Request virtual address |
| req_store | input | 1 | Request writes |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_user | input | 1 | Request is from user mode |
| pte_acc | input | 3 | Leaf entry access code |
| pte_mod | input | 1 | Leaf entry modified bit |
| walk_err | input | 1 | Walker reports a fault for this request |
| walk_code | input | WCODE_W | Walker fault bits ORed into the status word |
| nofault_en | input | 1 | No-fault control bit |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 0 status word, 1 fault address |
| fault_o | output | 1 | Fault raised for this request |
| trap_sel | output | 2 | 01 instruction trap, 10 data trap |
| grant_r | output | 1 | Read granted |
| grant_w | output | 1 | Write granted |
| grant_x | output | 1 | Execute granted |
| fsr_o | output | DATA_W | Current status word |
| far_o | output | VA_W | Current fault address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |

## Verification
The two functions that can meet in one cycle are a software read of the status word and the recording of a new fault. The read alone would clear the word, and the fault alone would mark overflow on a non-zero word. The bench first leaves a fault unread. It then drives a faulting request together with a status read, expects the read to return the old word, and expects the new word to hold the fresh fault with bit 0 clear. A second fault with no read in between is then expected to set bit 0.

// File: rtl/mmu_prot_check.sv
module mmu_prot_check #(
  parameter int VA_W    = 32,
  parameter int DATA_W  = 32,
  parameter int WCODE_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_va,
  input  logic               req_store,
  input  logic               req_fetch,
  input  logic               req_user,
  input  logic [2:0]         pte_acc,
  input  logic               pte_mod,
  input  logic               walk_err,
  input  logic [WCODE_W-1:0] walk_code,
  input  logic               nofault_en,
  input  logic               rd_en,
  input  logic               rd_sel,
  output logic               fault_o,
  output logic [1:0]         trap_sel,
  output logic               grant_r,
  output logic               grant_w,
  output logic               grant_x,
  output logic [DATA_W-1:0]  fsr_o,
  output logic [VA_W-1:0]    far_o,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data
);
  localparam int IDX_LSB  = 5;
  localparam int TYPE_LSB = 2;

  function automatic logic [1:0] ftype(input logic [2:0] idx, input logic [2:0] acc);
    logic [15:0] row;
    case (idx)
      3'd0: row = {2'd3, 2'd3, 2'd0, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0};
      3'd1: row = {2'd0, 2'd0, 2'd0, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0};
      3'd2: row = {2'd3, 2'd3, 2'd2, 2'd0, 2'd0, 2'd0, 2'd2, 2'd2};
      3'd3: row = {2'd0, 2'd0, 2'd2, 2'd0, 2'd0, 2'd0, 2'd2, 2'd2};
      3'd4: row = {2'd3, 2'd3, 2'd2, 2'd2, 2'd0, 2'd2, 2'd0, 2'd2};
      3'd5: row = {2'd0, 2'd2, 2'd0, 2'd2, 2'd0, 2'd2, 2'd0, 2'd2};
      3'd6: row = {2'd3, 2'd3, 2'd2, 2'd2, 2'd0, 2'd2, 2'd2, 2'd2};
      default: row = {2'd0, 2'd2, 2'd2, 2'd2, 2'd0, 2'd2, 2'd2, 2'd2};
    endcase
    return row[{acc, 1'b0} +: 2];
  endfunction

  function automatic logic [2:0] rights(input logic user, input logic [2:0] acc);
    case (acc)
      3'd0: return 3'b100;
      3'd1: return 3'b110;
      3'd2: return 3'b101;
      3'd3: return 3'b111;
      3'd4: return 3'b001;
      3'd5: return user ? 3'b100 : 3'b110;
      3'd6: return user ? 3'b000 : 3'b101;
      default: return user ? 3'b000 : 3'b111;
    endcase
  endfunction

  logic [2:0]        idx;
  logic [1:0]        ft;
  logic              nf_mask, prot_hit, record, give;
  logic [2:0]        rt;
  logic              rd_fsr;
  logic [DATA_W-1:0] code, fsr_q, fsr_seed;
  logic [VA_W-1:0]   far_q;

  assign idx      = {req_store, req_fetch, ~req_user};
  assign ft       = ftype(idx, pte_acc);
  assign prot_hit = ft != 2'd0;
  assign nf_mask  = nofault_en & req_user;
  assign record   = req_valid & (walk_err | (prot_hit & ~nf_mask));
  assign fault_o  = req_valid & (walk_err ? ~nofault_en : (prot_hit & ~nf_mask));
  assign trap_sel = !fault_o ? 2'b00 : (req_fetch ? 2'b01 : 2'b10);

  assign rt      = rights(req_user, pte_acc);
  assign give    = req_valid & ~walk_err & ~fault_o;
  assign grant_r = give & rt[2];
  assign grant_w = give & rt[1] & pte_mod;
  assign grant_x = give & rt[0];

  assign rd_fsr   = rd_en & ~rd_sel;
  assign code     = walk_err ? DATA_W'(walk_code) : (DATA_W'(ft) << TYPE_LSB);
  assign fsr_seed = (fsr_q != '0 && !rd_fsr) ? DATA_W'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q    <= '0;
      far_q    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_sel ? DATA_W'(far_q) : fsr_q;
      if (record) begin
        fsr_q <= fsr_seed | (DATA_W'(idx) << IDX_LSB) | code | DATA_W'(2);
        far_q <= req_va;
      end else if (rd_fsr) begin
        fsr_q <= '0;
      end
    end
  end

  assign fsr_o = fsr_q;
  assign far_o = far_q;
endmodule

module mmu_prot_check_chk #(
  parameter int VA_W   = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [VA_W-1:0]   req_va,
  input logic              req_fetch,
  input logic              req_user,
  input logic              pte_mod,
  input logic              walk_err,
  input logic              nofault_en,
  input logic              rd_en,
  input logic              rd_sel,
  input logic              fault_o,
  input logic [1:0]        trap_sel,
  input logic              grant_r,
  input logic              grant_w,
  input logic              grant_x,
  input logic [DATA_W-1:0] fsr_o,
  input logic [VA_W-1:0]   far_o,
  input logic              rd_valid
);
  AST_WRITE_NEEDS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    grant_w |-> pte_mod); // R5
  AST_FAULT_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !(grant_r || grant_w || grant_x)); // R4
  AST_TRAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trap_sel) && (fault_o || trap_sel == 2'b00)); // R8
  AST_FETCH_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o && req_fetch |-> trap_sel == 2'b01); // R8
  AST_NF_USER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && nofault_en && req_user && !walk_err |-> !fault_o); // R3
  AST_FSR_VALID_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fsr_o[1]); // R6
  AST_FAR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> far_o == $past(req_va)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o && fsr_o != '0 && !(rd_en && !rd_sel) |=> fsr_o[0]); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rd_sel && !req_valid |=> fsr_o == '0); // R11
  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R10
endmodule

bind mmu_prot_check mmu_prot_check_chk #(.VA_W(VA_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
  .req_fetch(req_fetch), .req_user(req_user), .pte_mod(pte_mod),
  .walk_err(walk_err), .nofault_en(nofault_en), .rd_en(rd_en), .rd_sel(rd_sel),
  .fault_o(fault_o), .trap_sel(trap_sel), .grant_r(grant_r), .grant_w(grant_w),
  .grant_x(grant_x), .fsr_o(fsr_o), .far_o(far_o), .rd_valid(rd_valid)
);

// File: tb/mmu_prot_check_tb_top.sv
module mmu_prot_check_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_store = 0, req_fetch = 0, req_user = 0;
  logic [31:0] req_va = '0;
  logic [2:0]  pte_acc = '0;
  logic        pte_mod = 0, walk_err = 0, nofault_en = 0, rd_en = 0, rd_sel = 0;
  logic [9:0]  walk_code = '0;
  logic        fault_o, grant_r, grant_w, grant_x, rd_valid;
  logic [1:0]  trap_sel;
  logic [31:0] fsr_o, far_o, rd_data;

  mmu_prot_check dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_store(req_store), .req_fetch(req_fetch), .req_user(req_user),
    .pte_acc(pte_acc), .pte_mod(pte_mod), .walk_err(walk_err),
    .walk_code(walk_code), .nofault_en(nofault_en), .rd_en(rd_en),
    .rd_sel(rd_sel), .fault_o(fault_o), .trap_sel(trap_sel),
    .grant_r(grant_r), .grant_w(grant_w), .grant_x(grant_x),
    .fsr_o(fsr_o), .far_o(far_o), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  logic [31:0] m_fsr = '0, m_far = '0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_rights(input logic user, input logic [2:0] acc);
    logic [2:0] r;
    case (acc)
      3'd0: r = 3'b100;  3'd1: r = 3'b110;  3'd2: r = 3'b101;  3'd3: r = 3'b111;
      3'd4: r = 3'b001;  3'd5: r = 3'b100;  default: r = 3'b000;
    endcase
    if (!user && acc == 3'd5) r = 3'b110;
    if (!user && acc == 3'd6) r = 3'b101;
    if (!user && acc == 3'd7) r = 3'b111;
    return r;
  endfunction

  function automatic logic [1:0] exp_type(input logic st, input logic fe, input logic us,
                                          input logic [2:0] acc);
    logic [2:0] have;
    logic miss;
    have = exp_rights(us, acc);
    if (us && acc >= 3'd6) return 2'd3;
    if (st || fe) miss = (st && !have[1]) || (fe && !have[0]);
    else          miss = !have[2];
    return miss ? 2'd2 : 2'd0;
  endfunction

  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) chk("R10", rd_data, 32'hxxxx_xxxx);
      else chk("R10", rd_data, exp_q.pop_front());
    end
  end

  task automatic step(input logic v, input logic [31:0] va, input logic st, input logic fe,
                      input logic us, input logic [2:0] acc, input logic md, input logic we,
                      input logic [9:0] wc, input logic nf, input logic re, input logic rs);
    logic [1:0] tv;
    logic supp, rec, rai, rdf;
    logic [2:0] rg, idx;
    logic [31:0] code;
    @(negedge clk);
    chk("R6", fsr_o, m_fsr);
    chk("R7", far_o, m_far);
    req_valid = v; req_va = va; req_store = st; req_fetch = fe; req_user = us;
    pte_acc = acc; pte_mod = md; walk_err = we; walk_code = wc; nofault_en = nf;
    rd_en = re; rd_sel = rs;
    #1;
    idx  = {st, fe, !us};
    tv   = exp_type(st, fe, us, acc);
    supp = nf && us;
    rec  = v && (we || (tv != 0 && !supp));
    rai  = v && (we ? !nf : (tv != 0 && !supp));
    rg   = (v && !we && !rai) ? exp_rights(us, acc) : 3'b000;
    if (!md) rg[1] = 1'b0;
    chk(we ? "R9" : (supp ? "R3" : "R2"), 32'(fault_o), 32'(rai));
    chk(md ? "R4" : "R5", 32'({grant_r, grant_w, grant_x}), 32'(rg));
    chk("R8", 32'(trap_sel), rai ? (fe ? 32'd1 : 32'd2) : 32'd0);
    if (re) exp_q.push_back(rs ? m_far : m_fsr);
    rdf  = re && !rs;
    code = we ? 32'(wc) : (32'(tv) << 2);
    if (rec) begin
      m_fsr = ((m_fsr != 0 && !rdf) ? 32'd1 : 32'd0) | (32'(idx) << 5) | code | 32'd2;
      m_far = va;
    end else if (rdf) m_fsr = '0;
  endtask

  task automatic idle(input logic re = 0, input logic rs = 0);
    step(0, '0, 0, 0, 0, 3'd0, 0, 0, '0, 0, re, rs);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", fsr_o, 0);
    chk("R12", far_o, 0);
    chk("R12", 32'(rd_valid), 0);
    chk("R12", rd_data, 0);
    idle(1, 0);
    idle(1, 1);
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 8; i++)
        for (int a = 0; a < 8; a++)
          step(1, 32'h1000_0000 + 32'((m * 64 + i * 8 + a) << 12) + 32'h123,
               i[2], i[1], !i[0], 3'(a), m[0], 0, '0, 0, a == 7, 0);
    idle(1, 0);
    idle();
    chk("R11", fsr_o, 0);
    // supervisor fetch on access code 0: index 3, type 2
    step(1, 32'hCAFE_1000, 0, 1, 0, 3'd0, 1, 0, '0, 0, 0, 0);
    idle();
    chk("R1", 32'(fsr_o[7:5]), 3);
    chk("R2", 32'(fsr_o[4:2]), 2);
    chk("R6", 32'(fsr_o[1:0]), 2);
    chk("R7", far_o, 32'hCAFE_1000);
    // second unread fault: user load on code 6 -> privilege, overflow
    step(1, 32'hBEEF_2000, 0, 0, 1, 3'd6, 1, 0, '0, 0, 0, 0);
    idle();
    chk("R6", 32'(fsr_o[0]), 1);
    chk("R2", 32'(fsr_o[4:2]), 3);
    // fault in the same cycle as a status read
    step(1, 32'h0ABC_3000, 1, 0, 1, 3'd0, 1, 0, '0, 0, 1, 0);
    idle();
    chk("R11", 32'(fsr_o[0]), 0);
    chk("R11", fsr_o, 32'h0000_008A);
    idle(1, 0);
    // no-fault mode: user store on read-only code, no record
    step(1, 32'h1111_4000, 1, 0, 1, 3'd0, 1, 0, '0, 1, 0, 0);
    idle();
    chk("R3", fsr_o, 0);
    // no-fault mode does not cover supervisor
    step(1, 32'h2222_5000, 1, 0, 0, 3'd0, 1, 0, '0, 1, 0, 0);
    idle(1, 0);
    // walker error, trapping then silent
    step(1, 32'h3333_6000, 0, 1, 1, 3'd3, 1, 1, 10'h204, 0, 0, 0);
    idle();
    chk("R9", fsr_o, 32'h0000_0246);
    step(1, 32'h4444_7000, 0, 0, 1, 3'd3, 1, 1, 10'h110, 1, 1, 0);
    idle();
    chk("R9", fsr_o, 32'h0000_0112);
    idle(1, 1);
    idle(1, 0);
    idle();
    idle();
    chk("R10", 32'(exp_q.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule